// File: doc/BRIEF.md
# Write-Back Single-Page Cache Controller

This block sits between a byte-addressed client and a page-level device sequencer. It keeps one page of the device in a local buffer, together with the page number the buffer holds and a dirty flag. A client request carries an operation code, a start address and a byte length. Requests that cross pages are cut into chunks, and each chunk stays inside one page. Write bytes enter through a valid/ready stream and read bytes leave through a second valid/ready stream. After the last chunk the block raises a one-cycle completion pulse that carries a success bit.

When a chunk targets a page other than the buffered one, the block first writes the buffer back to the device if it is dirty, and then reads the new page in. A write chunk that covers a whole page does not read the page in, because every byte is overwritten. An explicit flush writes a dirty buffer back and clears the flag. A pair of configuration operations always works on the last page of the device, starting at offset 0. The device side is a plain request/done handshake. During a write-back the block streams the page out one byte per cycle. During a fill the device pushes the page bytes in order.

Top module: `wb_page_cache`

## Requirements
- R1: After reset the block is idle with `req_ready` high, no device request and no output stream active. The buffer holds no page (all-ones page number), so the first access fills from the device without a write-back.
- R2: Operation codes are read=0, write=1, config read=2, config write=3, flush=4. A read or write whose start address is not below the data size, or whose start plus length exceeds the data size, completes with `op_ok`=0 and no device traffic. The data size is (DEV_PAGES-1) pages. Any code from 5 to 7 is also rejected this way.
- R3: The page number is the address above bit PAGE_W, and the offset is the low PAGE_W bits. Each chunk holds min(page size - offset, remaining length) bytes. Read bytes come out in address order and equal the last data written to those addresses, across page boundaries.
- R4: On a miss with a dirty buffer, the buffered page is written back to its own page number before the new page is filled. The device contents then match all client writes.
- R5: A chunk whose page equals the buffered page causes no device traffic.
- R6: A write chunk covering a full page on a miss performs no fill. It still writes back a dirty old page first.
- R7: Every accepted write byte marks the buffer dirty. A flush writes the page back only when dirty, then clears the flag, and it always completes with `op_ok`=1. A second flush causes no traffic.
- R8: Config operations ignore `req_addr` and use page DEV_PAGES-1 from offset 0. A length above one page is rejected with `op_ok`=0, and a length up to one page succeeds.
- R9: A request is accepted only while idle, and `req_ready` is low from the cycle after acceptance until completion. `op_done` is a single-cycle pulse after the final chunk, and zero-length requests complete with `op_ok`=1.
- R10: While `rd_valid` is high and `rd_ready` is low, the read byte is held. Gaps in `wr_valid` and `rd_ready` lose or duplicate no byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_kind | input | 3 | Operation code (see R2) |
| req_addr | input | ADDR_W | Start byte address |
| req_len | input | LEN_W | Length in bytes |
| wr_valid | input | 1 | Write byte offered |
| wr_ready | output | 1 | Write byte accepted |
| wr_data | input | 8 | Write byte |
| rd_valid | output | 1 | Read byte offered |
| rd_ready | input | 1 | Read byte taken |
| rd_data | output | 8 | Read byte |
| op_done | output | 1 | Completion pulse |
| op_ok | output | 1 | Success, valid with op_done |
| dev_req | output | 1 | Device operation in progress |
| dev_write | output | 1 | 1 = write-back, 0 = fill |
| dev_page | output | ADDR_W-PAGE_W | Device page number |
| dev_wvalid | output | 1 | Write-back byte valid |
| dev_wdata | output | 8 | Write-back byte |
| dev_fill_valid | input | 1 | Fill byte valid |
| dev_fill_data | input | 8 | Fill byte |
| dev_done | input | 1 | Device operation finished |

## Verification
The bench builds the block with 4-byte pages, four device pages, an 8-bit address and a 6-bit length, so the data region is 12 bytes and the config page is page 3. At that size every start and length pair inside the data region is written and read back. This covers chunks of every size, every page crossing, full-page write chunks, and dirty evictions in many orders. An arithmetic model in the bench predicts the write-back and fill counts of each request. Out-of-range starts, oversize config lengths, undefined codes and stream gaps are all reachable in a few thousand cycles.

// File: rtl/pc_pkg.sv
package pc_pkg;

  typedef enum logic [2:0] {
    OP_RD    = 3'd0,
    OP_WR    = 3'd1,
    OP_CRD   = 3'd2,
    OP_CWR   = 3'd3,
    OP_FLUSH = 3'd4
  } op_kind_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_CHUNK,
    S_WBSEND,
    S_WBWAIT,
    S_FILL,
    S_XFER,
    S_DONE
  } pc_state_e;

endpackage

// File: rtl/pc_page_ram.sv
module pc_page_ram #(
  parameter int PAGE_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [PAGE_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [PAGE_W-1:0] raddr,
  output logic [7:0]        rdata
);
  localparam int DEPTH = 1 << PAGE_W;

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];

endmodule

// File: rtl/pc_tag_reg.sv
module pc_tag_reg #(
  parameter int TAG_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_tag,
  input  logic [TAG_W-1:0] new_tag,
  input  logic             set_dirty,
  input  logic             clr_dirty,
  output logic [TAG_W-1:0] tag,
  output logic             dirty
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tag   <= '1;
      dirty <= 1'b0;
    end else begin
      if (set_tag) tag <= new_tag;
      if (set_dirty)      dirty <= 1'b1;
      else if (clr_dirty) dirty <= 1'b0;
    end
  end

endmodule

// File: rtl/wb_page_cache.sv
module wb_page_cache
  import pc_pkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int LEN_W     = 16,
  parameter int PAGE_W    = 8,
  parameter int DEV_PAGES = 512
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [2:0]               req_kind,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [LEN_W-1:0]         req_len,
  input  logic                     wr_valid,
  output logic                     wr_ready,
  input  logic [7:0]               wr_data,
  output logic                     rd_valid,
  input  logic                     rd_ready,
  output logic [7:0]               rd_data,
  output logic                     op_done,
  output logic                     op_ok,
  output logic                     dev_req,
  output logic                     dev_write,
  output logic [ADDR_W-PAGE_W-1:0] dev_page,
  output logic                     dev_wvalid,
  output logic [7:0]               dev_wdata,
  input  logic                     dev_fill_valid,
  input  logic [7:0]               dev_fill_data,
  input  logic                     dev_done
);

  localparam int PB        = 1 << PAGE_W;
  localparam int TAG_W     = ADDR_W - PAGE_W;
  localparam int CNT_W     = PAGE_W + 1;
  localparam int DATA_SIZE = (DEV_PAGES - 1) * PB;
  localparam int SW        = ((ADDR_W > LEN_W) ? ADDR_W : LEN_W) + 1;
  localparam int MW        = (LEN_W > CNT_W) ? LEN_W : CNT_W;
  localparam logic [TAG_W-1:0] CFG_TAG = TAG_W'(DEV_PAGES - 1);

  // bytes of this chunk: the room left in the page, capped by what remains
  function automatic logic [CNT_W-1:0] f_chunk(input logic [PAGE_W-1:0] off,
                                               input logic [LEN_W-1:0]  remain);
    logic [CNT_W-1:0] room;
    room = CNT_W'(PB) - CNT_W'(off);
    return (MW'(remain) < MW'(room)) ? CNT_W'(remain) : room;
  endfunction

  // the start must lie inside the data region, and so must the end
  function automatic logic f_in_range(input logic [ADDR_W-1:0] a,
                                      input logic [LEN_W-1:0]  n);
    logic [SW-1:0] last;
    last = SW'(a) + SW'(n);
    return (SW'(a) < SW'(DATA_SIZE)) && (last <= SW'(DATA_SIZE));
  endfunction

  function automatic logic f_cfg_len_ok(input logic [LEN_W-1:0] n);
    return SW'(n) <= SW'(PB);
  endfunction

  pc_state_e          st, st_nx;
  logic [2:0]         kind;
  logic [ADDR_W-1:0]  cur_addr;
  logic [LEN_W-1:0]   rem;
  logic [CNT_W-1:0]   clen;
  logic [CNT_W-1:0]   bidx;
  logic [CNT_W-1:0]   didx;
  logic               ok_r;

  logic [TAG_W-1:0]   tag;
  logic               dirty;
  logic               set_tag, set_dirty, clr_dirty;
  logic               ram_we;
  logic [PAGE_W-1:0]  ram_waddr, ram_raddr;
  logic [7:0]         ram_wdata, ram_q;
  logic               beat;
  logic               accept_ok;

  logic [TAG_W-1:0]   cur_page;
  logic [PAGE_W-1:0]  cur_off;
  logic [CNT_W-1:0]   chunk_len_w;
  logic               is_wr, is_cfg_req, hit, full_w;

  // named events for the checker
  logic               accept_evt, chunk_evt, miss_evt, fill_start_evt;

  assign cur_page    = cur_addr[ADDR_W-1:PAGE_W];
  assign cur_off     = cur_addr[PAGE_W-1:0];
  assign chunk_len_w = f_chunk(cur_off, rem);
  assign is_wr       = (kind == OP_WR) || (kind == OP_CWR);
  assign is_cfg_req  = (req_kind == OP_CRD) || (req_kind == OP_CWR);
  assign hit         = (cur_page == tag);
  assign full_w      = is_wr && (chunk_len_w == CNT_W'(PB));

  always_comb begin
    if (req_kind == OP_FLUSH)                          accept_ok = 1'b1;
    else if (req_kind == OP_RD || req_kind == OP_WR)   accept_ok = f_in_range(req_addr, req_len);
    else if (is_cfg_req)                               accept_ok = f_cfg_len_ok(req_len);
    else                                               accept_ok = 1'b0;
  end

  always_comb begin
    st_nx     = st;
    set_tag   = 1'b0;
    set_dirty = 1'b0;
    clr_dirty = 1'b0;
    ram_we    = 1'b0;
    ram_waddr = cur_off + bidx[PAGE_W-1:0];
    ram_wdata = wr_data;
    beat      = 1'b0;
    case (st)
      S_IDLE: begin
        if (req_valid) begin
          if (req_kind == OP_FLUSH) st_nx = dirty ? S_WBSEND : S_DONE;
          else                      st_nx = accept_ok ? S_CHUNK : S_DONE;
        end
      end
      S_CHUNK: begin
        if (rem == '0)   st_nx = S_DONE;
        else if (hit)    st_nx = S_XFER;
        else if (dirty)  st_nx = S_WBSEND;
        else if (full_w) begin
          set_tag = 1'b1;
          st_nx   = S_XFER;
        end else         st_nx = S_FILL;
      end
      S_WBSEND: begin
        if (didx == CNT_W'(PB - 1)) st_nx = S_WBWAIT;
      end
      S_WBWAIT: begin
        if (dev_done) begin
          clr_dirty = 1'b1;
          if (kind == OP_FLUSH) st_nx = S_DONE;
          else if (full_w) begin
            set_tag = 1'b1;
            st_nx   = S_XFER;
          end else st_nx = S_FILL;
        end
      end
      S_FILL: begin
        if (dev_fill_valid) begin
          ram_we    = 1'b1;
          ram_waddr = didx[PAGE_W-1:0];
          ram_wdata = dev_fill_data;
        end
        if (dev_done) begin
          set_tag = 1'b1;
          st_nx   = S_XFER;
        end
      end
      S_XFER: begin
        if (is_wr) begin
          if (wr_valid) begin
            ram_we    = 1'b1;
            set_dirty = 1'b1;
            beat      = 1'b1;
          end
        end else if (rd_ready) begin
          beat = 1'b1;
        end
        if (beat && (bidx == clen - CNT_W'(1))) st_nx = S_CHUNK;
      end
      S_DONE:  st_nx = S_IDLE;
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= 3'd0;
      cur_addr <= '0;
      rem      <= '0;
      clen     <= '0;
      bidx     <= '0;
      didx     <= '0;
      ok_r     <= 1'b0;
    end else begin
      st <= st_nx;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            kind     <= req_kind;
            ok_r     <= accept_ok;
            cur_addr <= is_cfg_req ? {CFG_TAG, PAGE_W'(0)} : req_addr;
            rem      <= req_len;
            didx     <= '0;
          end
        end
        S_CHUNK: begin
          clen <= chunk_len_w;
          bidx <= '0;
          didx <= '0;
        end
        S_WBSEND: didx <= didx + CNT_W'(1);
        S_WBWAIT: didx <= '0;
        S_FILL: begin
          if (dev_fill_valid) didx <= didx + CNT_W'(1);
        end
        S_XFER: begin
          if (beat) begin
            bidx <= bidx + CNT_W'(1);
            if (bidx == clen - CNT_W'(1)) begin
              cur_addr <= cur_addr + ADDR_W'(clen);
              rem      <= rem - LEN_W'(clen);
            end
          end
        end
        default: ;
      endcase
    end
  end

  assign ram_raddr = (st == S_WBSEND) ? didx[PAGE_W-1:0] : (cur_off + bidx[PAGE_W-1:0]);

  pc_page_ram #(.PAGE_W(PAGE_W)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_q)
  );

  pc_tag_reg #(.TAG_W(TAG_W)) u_tag (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_tag   (set_tag),
    .new_tag   (cur_page),
    .set_dirty (set_dirty),
    .clr_dirty (clr_dirty),
    .tag       (tag),
    .dirty     (dirty)
  );

  assign req_ready  = (st == S_IDLE);
  assign wr_ready   = (st == S_XFER) && is_wr;
  assign rd_valid   = (st == S_XFER) && !is_wr;
  assign rd_data    = ram_q;
  assign op_done    = (st == S_DONE);
  assign op_ok      = (st == S_DONE) && ok_r;
  assign dev_write  = (st == S_WBSEND) || (st == S_WBWAIT);
  assign dev_req    = dev_write || (st == S_FILL);
  assign dev_page   = (st == S_FILL) ? cur_page : tag;
  assign dev_wvalid = (st == S_WBSEND);
  assign dev_wdata  = ram_q;

  assign accept_evt     = (st == S_IDLE) && req_valid;
  assign chunk_evt      = (st == S_CHUNK) && (rem != '0);
  assign miss_evt       = chunk_evt && !hit;
  assign fill_start_evt = (st_nx == S_FILL) && (st != S_FILL);

endmodule

// File: rtl/pc_chk.sv
module pc_chk #(
  parameter int PAGE_W = 8,
  parameter int TAG_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              accept_evt,
  input logic              op_done,
  input logic              fill_start_evt,
  input logic              dirty,
  input logic              dev_wvalid,
  input logic [TAG_W-1:0]  tag,
  input logic              chunk_evt,
  input logic              miss_evt,
  input logic              dev_req,
  input logic              dev_write,
  input logic [PAGE_W:0]   clen_w,
  input logic [PAGE_W-1:0] cur_off,
  input logic              full_w,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [7:0]        rd_data
);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_evt |=> !req_ready);

  // R9
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    op_done |=> !op_done);

  // R4
  fill_after_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_start_evt |=> !dirty);

  // R1
  no_empty_writeback_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wvalid |-> (tag != '1));

  // R5
  hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chunk_evt && !miss_evt) |=> !dev_req);

  // R3
  chunk_in_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_evt |-> ((clen_w != '0) &&
                   ((PAGE_W+2)'(cur_off) + (PAGE_W+2)'(clen_w) <= (PAGE_W+2)'(1 << PAGE_W))));

  // R6
  full_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_evt && full_w) |=> !(dev_req && !dev_write));

  // R10
  read_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

bind wb_page_cache pc_chk #(.PAGE_W(PAGE_W), .TAG_W(TAG_W)) u_pc_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .req_ready      (req_ready),
  .accept_evt     (accept_evt),
  .op_done        (op_done),
  .fill_start_evt (fill_start_evt),
  .dirty          (dirty),
  .dev_wvalid     (dev_wvalid),
  .tag            (tag),
  .chunk_evt      (chunk_evt),
  .miss_evt       (miss_evt),
  .dev_req        (dev_req),
  .dev_write      (dev_write),
  .clen_w         (chunk_len_w),
  .cur_off        (cur_off),
  .full_w         (full_w),
  .rd_valid       (rd_valid),
  .rd_ready       (rd_ready),
  .rd_data        (rd_data)
);

// File: tb/test_wb_page_cache.sv
`timescale 1ns/1ps
module test_wb_page_cache;

  localparam int AW = 8, LW = 6, PW = 2, NP = 4;
  localparam int PB = 1 << PW;
  localparam int TW = AW - PW;
  localparam int DSZ = (NP - 1) * PB;
  localparam int TOT = NP * PB;
  localparam logic [2:0] K_RD = 3'd0, K_WR = 3'd1, K_CRD = 3'd2, K_CWR = 3'd3, K_FL = 3'd4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [2:0] req_kind = '0;
  logic [AW-1:0] req_addr = '0;
  logic [LW-1:0] req_len = '0;
  logic wr_valid = 1'b0;
  logic wr_ready;
  logic [7:0] wr_data = '0;
  logic rd_valid;
  logic rd_ready = 1'b0;
  logic [7:0] rd_data;
  logic op_done, op_ok;
  logic dev_req, dev_write;
  logic [TW-1:0] dev_page;
  logic dev_wvalid;
  logic [7:0] dev_wdata;
  logic dev_fill_valid = 1'b0;
  logic [7:0] dev_fill_data = '0;
  logic dev_done = 1'b0;

  always #2.5 clk = ~clk;

  wb_page_cache #(.ADDR_W(AW), .LEN_W(LW), .PAGE_W(PW), .DEV_PAGES(NP)) i_wb_page_cache (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
    .req_addr(req_addr), .req_len(req_len),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_data(wr_data),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .op_done(op_done), .op_ok(op_ok),
    .dev_req(dev_req), .dev_write(dev_write), .dev_page(dev_page),
    .dev_wvalid(dev_wvalid), .dev_wdata(dev_wdata),
    .dev_fill_valid(dev_fill_valid), .dev_fill_data(dev_fill_data),
    .dev_done(dev_done)
  );

  int ntests = 0, nfail = 0;
  int nwb = 0, nfill = 0;
  int cyc_all = 0;
  bit wd = 1'b0;
  logic [7:0] dmem [TOT];
  logic [7:0] gold [TOT];
  int m_tag = (1 << TW) - 1;
  bit m_dirty = 1'b0;
  int salt = 0;

  task automatic chk(input bit cond, input string rq, input string what, input int got, input int exp);
    ntests++;
    if (!cond) begin
      nfail++;
      $display("FAIL %s %s: got %0d exp %0d", rq, what, got, exp);
    end
  endtask

  // watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc_all++;
      if (cyc_all > 150000) wd = 1'b1;
    end
  end

  // device model: collects write-back bytes, serves fill bytes
  initial begin
    logic [7:0] wbuf [PB];
    int wcnt, fcnt;
    wcnt = 0;
    fcnt = 0;
    forever begin
      @(negedge clk);
      dev_done = 1'b0;
      dev_fill_valid = 1'b0;
      if (dev_req && dev_write) begin
        if (dev_wvalid) begin
          if (wcnt < PB) wbuf[wcnt] = dev_wdata;
          wcnt++;
        end else if (wcnt == PB) begin
          for (int i = 0; i < PB; i++)
            if (int'(dev_page) * PB + i < TOT) dmem[int'(dev_page) * PB + i] = wbuf[i];
          wcnt = 0;
          dev_done = 1'b1;
          nwb++;
        end
      end else if (dev_req && !dev_write) begin
        if (fcnt < PB) begin
          dev_fill_valid = 1'b1;
          dev_fill_data = (int'(dev_page) * PB + fcnt < TOT) ? dmem[int'(dev_page) * PB + fcnt] : 8'hxx;
          fcnt++;
        end else begin
          fcnt = 0;
          dev_done = 1'b1;
          nfill++;
        end
      end
    end
  end

  // requirement model of status and device traffic
  task automatic model_op(input logic [2:0] k, input int a, input int l,
                          output bit ok, output int wb, output int fl, output int base);
    int ad, r, off, pg, c;
    bit wr, full;
    ok = 1'b0; wb = 0; fl = 0; base = a;
    wr = (k == K_WR) || (k == K_CWR);
    if (k == K_FL) begin
      ok = 1'b1;
      if (m_dirty) begin wb = 1; m_dirty = 1'b0; end
      return;
    end
    if (k == K_RD || k == K_WR) ok = (a < DSZ) && (a + l <= DSZ);
    else if (k == K_CRD || k == K_CWR) begin ok = (l <= PB); base = (NP - 1) * PB; end
    if (!ok) return;
    ad = base; r = l;
    while (r > 0) begin
      off = ad % PB; pg = ad / PB;
      c = (PB - off < r) ? PB - off : r;
      full = wr && (c == PB);
      if (pg != m_tag) begin
        if (m_dirty) begin wb++; m_dirty = 1'b0; end
        if (!full) fl++;
        m_tag = pg;
      end
      if (wr) m_dirty = 1'b1;
      ad += c; r -= c;
    end
  endtask

  task automatic run_op(input logic [2:0] k, input int a, input int l, input bit bp);
    bit eok, seen, wr;
    int ewb, efl, base, wb0, f0, nr, kk, cyc, bad;
    logic got_ok;
    logic [7:0] exp_rd [16];
    logic [7:0] got [16];
    logic [7:0] wdat [16];
    wr = (k == K_WR) || (k == K_CWR);
    model_op(k, a, l, eok, ewb, efl, base);
    for (int i = 0; i < 16; i++) exp_rd[i] = (base + i < TOT) ? gold[base + i] : 8'h00;
    wb0 = nwb; f0 = nfill; nr = 0; kk = 0; cyc = 0; seen = 1'b0; got_ok = 1'b0;
    salt++;
    @(negedge clk);
    chk(req_ready == 1'b1, "R9", "ready while idle", req_ready, 1);
    req_valid = 1'b1; req_kind = k; req_addr = AW'(a); req_len = LW'(l);
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9", "ready after accept", req_ready, 0);
    while (!seen && !wd) begin
      wr_data  = 8'((base + kk) * 29 + salt * 11 + 3);
      wr_valid = wr && (kk < l) && (kk < 16) && (!bp || (cyc % 3 != 1));
      rd_ready = !bp || (cyc % 2 == 0);
      if (rd_valid && rd_ready) begin
        if (nr < 16) got[nr] = rd_data;
        nr++;
      end
      if (wr_ready && wr_valid) begin
        wdat[kk] = wr_data;
        kk++;
      end
      if (op_done) begin seen = 1'b1; got_ok = op_ok; end
      cyc++;
      if (!seen) @(negedge clk);
    end
    wr_valid = 1'b0; rd_ready = 1'b0;
    @(negedge clk);
    chk(op_done == 1'b0, "R9", "done is one pulse", op_done, 0);
    chk(got_ok == eok, "R2", $sformatf("status k%0d a%0d l%0d", k, a, l), got_ok, eok);
    chk(nwb - wb0 == ewb, "R4 R7", $sformatf("write-backs k%0d a%0d l%0d", k, a, l), nwb - wb0, ewb);
    chk(nfill - f0 == efl, "R5 R6", $sformatf("fills k%0d a%0d l%0d", k, a, l), nfill - f0, efl);
    if (eok && (k == K_RD || k == K_CRD)) begin
      bad = 0;
      for (int i = 0; i < l && i < 16; i++) if (got[i] !== exp_rd[i]) bad++;
      chk(nr == l, bp ? "R10" : "R3", "read byte count", nr, l);
      chk(bad == 0, bp ? "R10" : "R3", $sformatf("read bytes a%0d l%0d mismatches", base, l), bad, 0);
    end
    if (eok && wr) begin
      chk(kk == l, bp ? "R10" : "R3", "write bytes taken", kk, l);
      for (int i = 0; i < kk && i < 16; i++) gold[base + i] = wdat[i];
    end
    if (!eok) chk(kk == 0 && nr == 0, "R2", "no stream on reject", kk + nr, 0);
  endtask

  task automatic cmp_mem(input string rq);
    int bad;
    bad = 0;
    for (int i = 0; i < TOT; i++) if (dmem[i] !== gold[i]) bad++;
    chk(bad == 0, rq, "device contents after flush", bad, 0);
  endtask

  initial begin
    for (int i = 0; i < TOT; i++) begin
      dmem[i] = 8'(i * 37 + 5);
      gold[i] = dmem[i];
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1", "ready in reset", req_ready, 1);
    chk(dev_req == 1'b0, "R1", "no device request", dev_req, 0);
    chk(rd_valid == 1'b0 && wr_ready == 1'b0, "R1", "streams idle", rd_valid + wr_ready, 0);
    chk(op_done == 1'b0, "R1", "no done", op_done, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: empty buffer, first access fills without write-back
    run_op(K_RD, 0, 1, 1'b0);
    chk(nfill == 1 && nwb == 0, "R1", "first access traffic fills", nfill * 10 + nwb, 10);

    // R3 R4 R5 R6 R10: every start and length in the data region
    for (int a = 0; a < DSZ; a++)
      for (int l = 1; a + l <= DSZ; l++) begin
        run_op(K_WR, a, l, ((a + l) % 2) == 1);
        run_op(K_RD, a, l, (a % 2) == 1);
        if (wd) break;
      end

    // R7: flush writes back once, second flush is quiet
    run_op(K_FL, 0, 0, 1'b0);
    cmp_mem("R7");
    run_op(K_FL, 0, 0, 1'b0);

    // R6: full-page write on a miss with dirty buffer
    run_op(K_WR, 1, 1, 1'b0);
    run_op(K_WR, 8, 4, 1'b0);
    run_op(K_WR, 4, 8, 1'b1);
    run_op(K_RD, 0, 12, 1'b1);

    // R2: out-of-range starts and ends, undefined codes
    for (int a = 0; a < 16; a++) begin
      run_op(K_RD, a, (DSZ - a + 1 > 0) ? DSZ - a + 1 : 1, 1'b0);
      run_op(K_WR, a, 20, 1'b0);
    end
    run_op(3'd5, 0, 1, 1'b0);
    run_op(3'd7, 0, 1, 1'b0);

    // R9: zero-length inside range succeeds, outside fails
    run_op(K_RD, 3, 0, 1'b0);
    run_op(K_WR, 11, 0, 1'b0);
    run_op(K_RD, 12, 0, 1'b0);

    // R8: config page ignores the address, oversize rejected
    for (int l = 0; l <= PB + 1; l++) begin
      run_op(K_CWR, 5 * l, l, l % 2 == 1);
      run_op(K_CRD, 7, l, 1'b0);
    end
    run_op(K_RD, 2, 5, 1'b0);
    run_op(K_CRD, 0, PB, 1'b1);
    run_op(K_FL, 0, 0, 1'b0);
    cmp_mem("R8");

    if (wd) begin
      ntests++;
      nfail++;
      $display("FAIL R9 watchdog expired: got %0d exp %0d", cyc_all, 150000);
    end
    $display("  [TB] %0d tests run, %0d failed", ntests, nfail);
    $finish;
  end

endmodule